// File: doc/BRIEF.md
# Bilinear Event Splat Accumulator

This block builds an image of warped events for an iterative motion estimator. Each incoming event carries fixed-point x and y coordinates. The block splits each coordinate into an integer pixel index and a fraction. It then divides one unit of event weight among the four pixels that surround the event, giving each pixel a share based on the event's distance to it. These shares are added into accumulators held in on-chip RAM. The image is split into four banks chosen by the parity of the pixel's x and y, so the four updates for one event never compete for the same bank and all four are issued in the same cycle.

After all events of an optimizer pass have been offered, a scan request drains the update pipeline. The block then streams every pixel out in raster order and ends the stream with a one-cycle done pulse. The RAM has no reset, so the block writes zero into each location one cycle after reading it. The image is therefore empty again when the next pass starts. The bank RAMs also power up unknown, so one scan is needed after power-up before the first pass.

Top module: `bilinear_vote_accum`

## Requirements
- R1: After reset, `ev_ready` is 1, `px_valid` is 0 and `scan_done` is 0.
- R2: The low FRAC bits of `ev_x`/`ev_y` are the fractions fx, fy, counted in units of 1/2^FRAC. The upper bits are the integer pixel indices x0, y0. An event adds (2^FRAC-fx)(2^FRAC-fy) to (x0,y0), fx(2^FRAC-fy) to (x0+1,y0), (2^FRAC-fx)fy to (x0,y0+1) and fx·fy to (x0+1,y0+1). One unit of weight is 2^(2·FRAC).
- R3: For an event whose four neighbours all lie inside the image, the four added amounts total exactly 2^(2·FRAC).
- R4: A neighbour with column ≥ IMG_W or row ≥ IMG_H is dropped, and the other neighbours of that event are still added. `ev_ready` stays 1 during such events, so the pipeline does not stall.
- R5: Events offered back to back, including repeated hits on the same pixel and bank address, accumulate to the exact sum of their weights.
- R6: Each accumulator saturates at 2^ACC_W-1 and never wraps.
- R7: After a `scan_start` pulse, exactly IMG_W·IMG_H pixels are output with `px_valid`, in raster order (x fastest, then y). `scan_done` is high for one cycle, in the cycle after the last pixel.
- R8: A scan leaves every pixel at zero. A second scan with no events between the two yields all zeros, and the next pass accumulates from zero.
- R9: `ev_ready` is 0 from the cycle after `scan_start` is accepted until `scan_done`. While `scan_done` is high, `ev_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block accepts events (accumulate phase) |
| ev_x | input | $clog2(IMG_W)+FRAC+1 | Warped x, unsigned fixed point, FRAC fraction bits |
| ev_y | input | $clog2(IMG_H)+FRAC+1 | Warped y, unsigned fixed point, FRAC fraction bits |
| scan_start | input | 1 | Pulse: drain, then read out and clear the image |
| px_valid | output | 1 | `px_data` holds the next raster pixel |
| px_data | output | ACC_W | Accumulated pixel value |
| scan_done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench builds the block with an 8 by 6 image, 4 fraction bits and 16-bit accumulators. This size is small enough to compare every pixel of every scan against an arithmetic model. It sweeps every integer position, including columns and rows past the edge, with varied fractions, and then all 256 fraction pairs at one point. The 16-bit accumulator reaches saturation after 256 unit-weight events at one pixel, so back-to-back forwarding to one bank address and the clamp at 65535 are both exercised in a few hundred cycles.

// File: rtl/bilinear_vote_accum.sv
module bilinear_vote_accum #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 32,
  parameter int FRAC  = 4,
  parameter int ACC_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_valid,
  output logic                          ev_ready,
  input  logic [$clog2(IMG_W)+FRAC:0]   ev_x,
  input  logic [$clog2(IMG_H)+FRAC:0]   ev_y,
  input  logic                          scan_start,
  output logic                          px_valid,
  output logic [ACC_W-1:0]              px_data,
  output logic                          scan_done
);

  localparam int XIW   = $clog2(IMG_W) + 1;
  localparam int YIW   = $clog2(IMG_H) + 1;
  localparam int SXW   = $clog2(IMG_W);
  localparam int SYW   = $clog2(IMG_H);
  localparam int HW    = IMG_W / 2;
  localparam int DEPTH = (IMG_W / 2) * (IMG_H / 2);
  localparam int AW    = $clog2(DEPTH);
  localparam int WW    = 2 * FRAC + 1;

  localparam logic [FRAC:0]  UNIT_F = (FRAC+1)'(1 << FRAC);
  localparam logic [WW-1:0]  UNIT_W = WW'(1 << (2 * FRAC));
  localparam logic [XIW:0]   X_LIM  = (XIW+1)'(IMG_W);
  localparam logic [YIW:0]   Y_LIM  = (YIW+1)'(IMG_H);
  localparam logic [SXW-1:0] X_LAST = SXW'(IMG_W - 1);
  localparam logic [SYW-1:0] Y_LAST = SYW'(IMG_H - 1);

  typedef enum logic [1:0] {ST_ACC, ST_DRAIN, ST_SCAN} st_t;
  st_t state;

  logic [XIW-1:0]  xi;
  logic [YIW-1:0]  yi;
  logic [FRAC-1:0] fx, fy;
  logic            accept;

  assign xi       = ev_x[FRAC +: XIW];
  assign yi       = ev_y[FRAC +: YIW];
  assign fx       = ev_x[FRAC-1:0];
  assign fy       = ev_y[FRAC-1:0];
  assign ev_ready = (state == ST_ACC);
  assign accept   = ev_valid && ev_ready;

  logic [SXW-1:0] sx;
  logic [SYW-1:0] sy;
  logic           sc_rd;
  logic           rd_valid_q;
  logic [1:0]     rd_bank_q;
  logic [AW-1:0]  rd_addr_q;
  logic           rd_last_q;
  logic [AW-1:0]  scan_addr;
  logic           scan_last;

  assign scan_addr = AW'(32'(sy >> 1) * HW + 32'(sx >> 1));
  assign scan_last = (sx == X_LAST) && (sy == Y_LAST);

  logic [3:0]       s1_vb, s2_vb;
  logic [WW-1:0]    s1_wb   [4];
  logic [ACC_W-1:0] bank_rd [4];

  for (genvar b = 0; b < 4; b++) begin : g_bank
    localparam logic BX = 1'(b % 2);
    localparam logic BY = 1'(b / 2);

    logic [XIW:0]  nx;
    logic [YIW:0]  ny;
    logic [FRAC:0] wx, wy;
    logic          hit;
    logic [AW-1:0] na;
    logic [WW-1:0] nw;

    always_comb begin
      nx  = {1'b0, xi} + ((xi[0] == BX) ? '0 : (XIW+1)'(1));
      ny  = {1'b0, yi} + ((yi[0] == BY) ? '0 : (YIW+1)'(1));
      wx  = (xi[0] == BX) ? UNIT_F - {1'b0, fx} : {1'b0, fx};
      wy  = (yi[0] == BY) ? UNIT_F - {1'b0, fy} : {1'b0, fy};
      hit = (nx < X_LIM) && (ny < Y_LIM);
      na  = AW'(32'(ny >> 1) * HW + 32'(nx >> 1));
      nw  = {{FRAC{1'b0}}, wx} * {{FRAC{1'b0}}, wy};
    end

    logic             v1, v2, v3;
    logic [AW-1:0]    a1, a2, a3;
    logic [WW-1:0]    w1, w2;
    logic [ACC_W-1:0] d3, rd, src, sum;
    logic [ACC_W:0]   ext;
    logic             clr, we;
    logic [AW-1:0]    wa, ra;
    logic [ACC_W-1:0] wd;
    logic [ACC_W-1:0] mem [DEPTH];

    assign src = (v3 && a3 == a2) ? d3 : rd;
    assign ext = {1'b0, src} + {{(ACC_W+1-WW){1'b0}}, w2};
    assign sum = ext[ACC_W] ? '1 : ext[ACC_W-1:0];
    assign clr = rd_valid_q && (rd_bank_q == 2'(b));
    assign we  = clr || v2;
    assign wa  = clr ? rd_addr_q : a2;
    assign wd  = clr ? '0 : sum;
    assign ra  = (state == ST_SCAN) ? scan_addr : a1;

    always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rd <= mem[ra];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v1 <= 1'b0;
        v2 <= 1'b0;
        v3 <= 1'b0;
        a1 <= '0;
        a2 <= '0;
        a3 <= '0;
        w1 <= '0;
        w2 <= '0;
        d3 <= '0;
      end else begin
        v1 <= accept && hit;
        a1 <= na;
        w1 <= nw;
        v2 <= v1;
        a2 <= a1;
        w2 <= w1;
        v3 <= v2 && (state != ST_SCAN);
        a3 <= a2;
        d3 <= sum;
      end
    end

    assign s1_vb[b]   = v1;
    assign s2_vb[b]   = v2;
    assign s1_wb[b]   = w1;
    assign bank_rd[b] = rd;

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      v2 |-> (sum >= src));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_ACC;
      sx         <= '0;
      sy         <= '0;
      sc_rd      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_bank_q  <= '0;
      rd_addr_q  <= '0;
      rd_last_q  <= 1'b0;
      scan_done  <= 1'b0;
    end else begin
      scan_done  <= rd_valid_q && rd_last_q;
      rd_valid_q <= sc_rd;
      if (sc_rd) begin
        rd_bank_q <= {sy[0], sx[0]};
        rd_addr_q <= scan_addr;
        rd_last_q <= scan_last;
        if (scan_last) sc_rd <= 1'b0;
        else if (sx == X_LAST) begin
          sx <= '0;
          sy <= sy + 1'b1;
        end else sx <= sx + 1'b1;
      end
      case (state)
        ST_ACC:   if (scan_start) state <= ST_DRAIN;
        ST_DRAIN: if (s1_vb == '0 && s2_vb == '0) begin
          state <= ST_SCAN;
          sx    <= '0;
          sy    <= '0;
          sc_rd <= 1'b1;
        end
        ST_SCAN:  if (rd_valid_q && rd_last_q) state <= ST_ACC;
        default:  state <= ST_ACC;
      endcase
    end
  end

  assign px_valid = rd_valid_q;
  assign px_data  = bank_rd[rd_bank_q];

  a_r3_unit_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (&s1_vb) |-> (s1_wb[0] + s1_wb[1] + s1_wb[2] + s1_wb[3] == UNIT_W));

  a_r7_px_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (state == ST_SCAN));

  a_r7_done_follows_px: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> ($past(px_valid) && !px_valid));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  a_r9_ready_during_readout: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> !ev_ready);

  a_r9_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> ev_ready);

endmodule

// File: tb/bilinear_vote_accum_test.sv
`timescale 1ns/1ps
module bilinear_vote_accum_test;
  localparam int W = 8, H = 6, F = 4, AW = 16;
  localparam int UNIT = 1 << F;
  localparam int MAXV = (1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_ready;
  logic [$clog2(W)+F:0] ev_x = '0;
  logic [$clog2(H)+F:0] ev_y = '0;
  logic scan_start = 0, px_valid, scan_done;
  logic [AW-1:0] px_data;

  bilinear_vote_accum #(.IMG_W(W), .IMG_H(H), .FRAC(F), .ACC_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_x(ev_x), .ev_y(ev_y), .scan_start(scan_start), .px_valid(px_valid),
    .px_data(px_data), .scan_done(scan_done));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int expv [H][W];
  int scan_total;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int want);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, want);
    end
  endtask

  task automatic model_add(input int ix, input int iy, input int fx, input int fy);
    for (int dy = 0; dy < 2; dy++)
      for (int dx = 0; dx < 2; dx++) begin
        int px = ix + dx, py = iy + dy;
        int w = (dx ? fx : UNIT - fx) * (dy ? fy : UNIT - fy);
        if (px < W && py < H) begin
          expv[py][px] = expv[py][px] + w;
          if (expv[py][px] > MAXV) expv[py][px] = MAXV;
        end
      end
  endtask

  task automatic send(input int ix, input int iy, input int fx, input int fy);
    ev_x = {4'(ix), 4'(fx)};
    ev_y = {4'(iy), 4'(fy)};
    ev_valid = 1;
    chk(ev_ready == 1, "R4 ready during events", int'(ev_ready), 1);
    model_add(ix, iy, fx, fy);
    @(negedge clk);
  endtask

  task automatic end_events();
    ev_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_scan(input string tag, input bit compare);
    int idx = 0;
    bit prev_last = 0;
    bit got_done = 0;
    scan_total = 0;
    scan_start = 1;
    @(negedge clk);
    scan_start = 0;
    for (int c = 0; c < 400 && !got_done; c++) begin
      @(negedge clk);
      if (scan_done) begin
        got_done = 1;
        chk(prev_last && !px_valid, "R7 done one cycle after last pixel", int'(prev_last), 1);
        chk(ev_ready == 1, "R9 ready back at done", int'(ev_ready), 1);
      end
      if (px_valid) begin
        chk(ev_ready == 0, "R9 ready low in readout", int'(ev_ready), 0);
        if (compare && idx < W * H)
          chk(int'(px_data) == expv[idx / W][idx % W], tag, int'(px_data), expv[idx / W][idx % W]);
        scan_total += int'(px_data);
        idx++;
      end
      prev_last = px_valid && (idx == W * H);
    end
    chk(got_done, "R7 done pulse seen", int'(got_done), 1);
    chk(idx == W * H, "R7 pixel count", idx, W * H);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) expv[y][x] = 0;
  endtask

  initial begin
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) expv[y][x] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ev_ready == 1, "R1 ev_ready", int'(ev_ready), 1);
    chk(px_valid == 0, "R1 px_valid", int'(px_valid), 0);
    chk(scan_done == 0, "R1 scan_done", int'(scan_done), 0);

    do_scan("flush", 0);

    // R2 and R4: every integer position, past the edges included
    for (int iy = 0; iy <= H; iy++)
      for (int ix = 0; ix <= W; ix++)
        send(ix, iy, (ix * 5 + iy * 3) % 16, (ix * 7 + iy * 11 + 1) % 16);
    send(15, 15, 3, 9);
    send(W - 1, 2, 6, 4);
    send(3, H - 1, 0, 12);
    end_events();
    do_scan("R2 R4 pixel", 1);

    // R3 single interior event
    send(3, 2, 5, 9);
    end_events();
    do_scan("R3 pixel", 1);
    chk(scan_total == UNIT * UNIT, "R3 weight total", scan_total, UNIT * UNIT);

    // R5 all fraction pairs back to back at one point
    for (int fy = 0; fy < 16; fy++)
      for (int fx = 0; fx < 16; fx++) send(2, 3, fx, fy);
    for (int k = 0; k < 6; k++) send(4, 1, 8, 8);
    end_events();
    do_scan("R5 pixel", 1);

    // R6 saturation
    for (int k = 0; k < 260; k++) send(5, 4, 0, 0);
    end_events();
    do_scan("R6 pixel", 1);

    // R8 image left empty
    do_scan("R8 pixel", 1);
    send(1, 1, 4, 4);
    end_events();
    do_scan("R8 fresh pass", 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule